// File: doc/BRIEF.md
# SMBus Host Status and Interrupt Register

This block is the status byte of a bus host controller for SMBus. It tracks whether a command is running and latches why the last command ended: success, device error, bus collision or forced termination. It also latches an external alert request and raises a single interrupt line when any of these conditions needs service. Software clears each latched condition by writing a one to its bit.

The same byte carries a hardware semaphore. Several independent software agents can share the controller through it. An agent reads the byte: if the semaphore bit comes back 0, that agent now owns the controller, because the read itself set the bit. The owner releases the controller by writing a 1 to that bit. The transaction engine drives single-cycle event pulses into the block. The block drives a registered read-data byte and a registered interrupt.

Top module: `smb_host_status`

## Requirements
- R1: After a synchronous active-high reset, every status bit is 0, `irq` is 0 and `rd_data` is 0.
- R2: The status byte layout is: bit 0 busy, bit 1 completion, bit 2 device error, bit 3 bus error, bit 4 failed, bit 5 alert, bit 6 in-use. Bit 7 always reads 0.
- R3: A read returns the in-use bit as it stood before the read, and the read sets it. The first read after reset therefore returns 0, and later reads return 1.
- R4: Writing 1 to bit 6 clears the in-use bit, and writing 0 to bit 6 leaves it unchanged. This holds even while busy is set. When a read and a clearing write occur in the same cycle, the bit ends up cleared.
- R5: `ev_start` sets busy. Any termination pulse (`ev_done`, any `ev_dev_cause` bit, `ev_collision`, `ev_killed`) clears busy, and `ev_start` wins if both occur in the same cycle. Writes never change busy.
- R6: `ev_done` sets the completion bit whether or not `int_en` is high. The completion bit drives `irq` only while `int_en` is high.
- R7: The device-error bit sets when any of the three `ev_dev_cause` bits is high. Bit 0 is an illegal command, bit 1 an unclaimed cycle and bit 2 a device time-out.
- R8: `ev_collision` sets the bus-error bit, and `ev_killed` sets the failed bit.
- R9: The alert bit sets in any cycle where `alert_in` is high and `alert_is_gpio` is low. It never sets while `alert_is_gpio` is high.
- R10: A write while not busy clears each of bits 1 to 5 where the written data holds a 1. A 0 in the written data leaves the bit unchanged. When a set event and a clear arrive in the same cycle, the bit ends up set.
- R11: `irq` is registered. It updates on the same edge as the flags, and equals (completion AND `int_en`) OR device error OR bus error OR failed OR alert.
- R12: A write that arrives while busy is set clears none of bits 1 to 5.
- R13: `rd_data` captures the status byte on the edge where `rd_en` is high, using the state before that edge. It holds its value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Status byte read strobe |
| wr_en | input | 1 | Status byte write strobe |
| wr_data | input | 8 | Write data, one bit per flag to clear |
| rd_data | output | 8 | Registered read data |
| ev_start | input | 1 | Command launched |
| ev_done | input | 1 | Command completed successfully |
| ev_dev_cause | input | 3 | Device error causes: illegal command, unclaimed, time-out |
| ev_collision | input | 1 | Transaction collision |
| ev_killed | input | 1 | Transaction terminated by kill |
| alert_in | input | 1 | Alert pin level |
| alert_is_gpio | input | 1 | Alert pin used as general-purpose I/O |
| int_en | input | 1 | Completion interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Every flag, busy and `irq` take their new value on the first clock edge after the input is applied, so their effect is due one cycle later. A read's result appears in `rd_data` after that same edge, and it shows the state from before the edge. The bench drives inputs just after a falling edge and keeps a model that advances once per rising edge. At the next falling edge it compares `irq` and `rd_data` with the model. Flag effects are observed through reads issued one cycle after the stimulus.

// File: rtl/smb_sts_pkg.sv
package smb_sts_pkg;
  localparam int STS_W   = 8;
  localparam int B_BUSY  = 0;
  localparam int B_DONE  = 1;
  localparam int B_DEV   = 2;
  localparam int B_BUS   = 3;
  localparam int B_FAIL  = 4;
  localparam int B_ALERT = 5;
  localparam int B_INUSE = 6;
  localparam int NFLAG   = B_ALERT - B_DONE + 1;
  localparam int FLAG_LSB = B_DONE;
endpackage

// File: rtl/smb_sts_flags.sv
module smb_sts_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] d_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // a set event outranks a clear in the same cycle
    assign d_o[i] = set_i[i] | (q_o[i] & ~clr_i[i]);
    always_ff @(posedge clk) begin
      if (rst) q_o[i] <= 1'b0;
      else     q_o[i] <= d_o[i];
    end
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> q_o[i]);
  end
endmodule

// File: rtl/smb_sts_sem.sv
module smb_sts_sem (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (rd_i)  q_o <= 1'b1;
  end

  assert_read_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !clr_i) |=> q_o);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q_o);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/smb_host_status.sv
module smb_host_status
  import smb_sts_pkg::*;
#(
  parameter int NCAUSE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [STS_W-1:0]  wr_data,
  output logic [STS_W-1:0]  rd_data,
  input  logic              ev_start,
  input  logic              ev_done,
  input  logic [NCAUSE-1:0] ev_dev_cause,
  input  logic              ev_collision,
  input  logic              ev_killed,
  input  logic              alert_in,
  input  logic              alert_is_gpio,
  input  logic              int_en,
  output logic              irq
);
  localparam int FI_DONE  = B_DONE  - FLAG_LSB;
  localparam int FI_DEV   = B_DEV   - FLAG_LSB;
  localparam int FI_BUS   = B_BUS   - FLAG_LSB;
  localparam int FI_FAIL  = B_FAIL  - FLAG_LSB;
  localparam int FI_ALERT = B_ALERT - FLAG_LSB;

  logic             busy_q;
  logic             inuse_q;
  logic             term;
  logic             wr_ok;
  logic [NFLAG-1:0] flg_set, flg_clr, flg_q, flg_d;
  logic [STS_W-1:0] status;

  assign term  = ev_done | (|ev_dev_cause) | ev_collision | ev_killed;
  assign wr_ok = wr_en & ~busy_q;

  always_comb begin
    flg_set           = '0;
    flg_set[FI_DONE]  = ev_done;
    flg_set[FI_DEV]   = |ev_dev_cause;
    flg_set[FI_BUS]   = ev_collision;
    flg_set[FI_FAIL]  = ev_killed;
    flg_set[FI_ALERT] = alert_in & ~alert_is_gpio;
  end

  assign flg_clr = wr_ok ? wr_data[B_ALERT:B_DONE] : '0;

  smb_sts_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(flg_set), .clr_i(flg_clr),
    .q_o(flg_q), .d_o(flg_d)
  );

  smb_sts_sem u_sem (
    .clk(clk), .rst(rst), .rd_i(rd_en),
    .clr_i(wr_en & wr_data[B_INUSE]), .q_o(inuse_q)
  );

  always_ff @(posedge clk) begin
    if (rst)           busy_q <= 1'b0;
    else if (ev_start) busy_q <= 1'b1;
    else if (term)     busy_q <= 1'b0;
  end

  always_comb begin
    status          = '0;
    status[B_BUSY]  = busy_q;
    status[B_ALERT:B_DONE] = flg_q;
    status[B_INUSE] = inuse_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_en) rd_data <= status;
      irq <= (flg_d[FI_DONE] & int_en) | flg_d[FI_DEV] | flg_d[FI_BUS]
           | flg_d[FI_FAIL] | flg_d[FI_ALERT];
    end
  end

  assert_done_latch_R6: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> flg_q[FI_DONE]);
  assert_kill_R8: assert property (@(posedge clk) disable iff (rst)
    ev_killed |=> flg_q[FI_FAIL]);
  assert_gpio_alert_R9: assert property (@(posedge clk) disable iff (rst)
    (alert_is_gpio && !flg_q[FI_ALERT]) |=> !flg_q[FI_ALERT]);
  assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> busy_q);
  assert_busy_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data[STS_W-1] || wr_data[B_BUSY]) && !ev_start && !term)
      |=> busy_q == $past(busy_q));
  assert_busy_wr_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_q) |=> ((flg_q & $past(flg_q)) == $past(flg_q)));
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (flg_q == '0) |-> !irq);
  assert_bit7_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_data[STS_W-1]);
endmodule

// File: tb/test_smb_host_status.sv
module test_smb_host_status;
  logic clk = 0, rst = 1;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic ev_start = 0, ev_done = 0, ev_collision = 0, ev_killed = 0;
  logic [2:0] ev_dev_cause = 0;
  logic alert_in = 0, alert_is_gpio = 0, int_en = 0, irq;
  int total = 0, bad = 0;

  // model of the status byte built from the requirements
  logic m_busy, m_inuse, m_irq;
  logic [4:0] m_flags;
  logic [7:0] m_rd;

  always #5 clk = ~clk;

  smb_host_status i_smb_host_status (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ev_start(ev_start), .ev_done(ev_done),
    .ev_dev_cause(ev_dev_cause), .ev_collision(ev_collision),
    .ev_killed(ev_killed), .alert_in(alert_in), .alert_is_gpio(alert_is_gpio),
    .int_en(int_en), .irq(irq));

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic clear_in();
    rd_en = 0; wr_en = 0; wr_data = 0; ev_start = 0; ev_done = 0;
    ev_dev_cause = 0; ev_collision = 0; ev_killed = 0; alert_in = 0;
  endtask

  // advance one clock from the current inputs, then compare outputs
  task automatic tick(string req);
    logic term, wok;
    logic [4:0] set, clr, nf;
    term = ev_done | (|ev_dev_cause) | ev_collision | ev_killed;
    wok  = wr_en & ~m_busy;
    set  = {alert_in & ~alert_is_gpio, ev_killed, ev_collision, |ev_dev_cause, ev_done};
    clr  = wok ? wr_data[5:1] : 5'b0;
    nf   = set | (m_flags & ~clr);
    if (rd_en) m_rd = {1'b0, m_inuse, m_flags, m_busy};
    m_inuse = (wr_en && wr_data[6]) ? 1'b0 : (rd_en ? 1'b1 : m_inuse);
    m_busy  = ev_start ? 1'b1 : (term ? 1'b0 : m_busy);
    m_irq   = (nf[0] & int_en) | (|nf[4:1]);
    m_flags = nf;
    @(posedge clk);
    @(negedge clk);
    chk({req, " irq R11"}, {7'b0, irq}, {7'b0, m_irq});
    chk({req, " rd_data R13"}, rd_data, m_rd);
    clear_in();
  endtask

  task automatic rd_expect(string req, logic [7:0] exp);
    rd_en = 1;
    tick(req);
    chk(req, rd_data, exp);
  endtask

  task automatic wr(logic [7:0] d, string req);
    wr_en = 1; wr_data = d;
    tick(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed));
    m_busy = 0; m_inuse = 0; m_irq = 0; m_flags = 0; m_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    // R3 semaphore: first read 0, then 1
    rd_expect("R3 first read", 8'h00);
    rd_expect("R3 second read", 8'h40);
    // R4: write 0 keeps, write 1 releases
    wr(8'h00, "R4 write0");
    rd_expect("R4 kept", 8'h40);
    wr(8'h40, "R4 write1");
    rd_expect("R4 released", 8'h00);
    // R5 busy set and cleared; R12 write while busy ignored
    ev_collision = 1; tick("R8 collision");
    ev_start = 1; tick("R5 start");
    rd_expect("R5 busy R8 bus err", 8'h49);
    wr(8'h48, "R12 write while busy");
    rd_expect("R12 flag kept, R4 inuse cleared", 8'h09);
    ev_killed = 1; tick("R8 kill");
    rd_expect("R5 busy cleared R8 failed", 8'h58);
    wr(8'h18, "R10 clear");
    rd_expect("R10 cleared", 8'h40);
    // R6 completion masked, then enabled
    int_en = 0; ev_done = 1; tick("R6 done masked");
    chk("R6 irq masked", {7'b0, irq}, 8'h00);
    int_en = 1; tick("R6 enable");
    chk("R6 irq enabled", {7'b0, irq}, 8'h01);
    rd_expect("R2 completion bit1", 8'h42);
    // R10 event wins over clear in same cycle
    wr_en = 1; wr_data = 8'h02; ev_done = 1; tick("R10 same cycle");
    rd_expect("R10 event wins", 8'h42);
    wr(8'h02, "R10 clear done");
    chk("R11 irq off", {7'b0, irq}, 8'h00);
    // R7 each cause
    for (int c = 0; c < 3; c++) begin
      ev_dev_cause = 3'b1 << c; tick("R7 cause");
      rd_expect("R7 dev err", 8'h44);
      wr(8'h04, "R7 clear");
    end
    // R9 alert in gpio mode ignored, else latched
    alert_is_gpio = 1; alert_in = 1; tick("R9 gpio");
    rd_expect("R9 gpio no alert", 8'h40);
    alert_is_gpio = 0; alert_in = 1; tick("R9 alert");
    chk("R11 alert irq", {7'b0, irq}, 8'h01);
    rd_expect("R9 alert set", 8'h60);
    wr(8'h60, "R10 clear alert");
    // R13 hold without read
    tick("R13 hold");
    chk("R13 hold", rd_data, 8'h60);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      r = $urandom;
      rd_en        = (r[3:0] < 3);
      wr_en        = (r[7:4] < 3);
      wr_data      = 8'($urandom);
      ev_start     = (r[11:8] == 0);
      ev_done      = (r[15:12] == 0);
      ev_dev_cause = (r[19:16] == 0) ? 3'($urandom) : 3'b0;
      ev_collision = (r[23:20] == 0);
      ev_killed    = (r[27:24] == 0);
      alert_in     = (r[31:28] == 0);
      alert_is_gpio = r[5] & r[9];
      int_en       = r[13] | r[17];
      tick("R10 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule